// File: doc/BRIEF.md
# Packed-Opcode Cell Fetch and Call Sequencer

This block steps an instruction pointer through a word-addressed program memory whose reads are registered. Each 32-bit cell is one of two kinds. If its two tag bits are zero, the cell is a subroutine call: the remaining bits give the target. Any other tag value marks an opcode cell, which holds five 6-bit opcode lanes. The sequencer spends one cycle taking in a cell and then one cycle on each opcode it holds. It shows every opcode, with its lane number, to an external execute unit.

The execute unit controls progress through an advance input. While this input is low, the sequencer holds the current opcode and the current address. Return and repeat codes are handled inside the sequencer. A return reloads the pointer from a return stack that lives outside the block. A repeat restarts the same cell at lane 0 without reading memory again.

Interrupts are accepted only at a point where a cell ends or a loop wraps. The address pushed is the one that lets execution resume correctly: the following cell, or the looping cell itself.

The memory address output is the pointer value for the coming cycle. The RAM can therefore register it at the edge that starts the cycle that consumes the data.

Top module: `cell_sequencer`

## Requirements
- R1: While reset is asserted, and in the first cycle after release, no opcode is valid and `mem_addr` is 0. The next cycle takes in the cell at address 0.
- R2: In an opcode cell, lane i occupies bits [6i+7:6i+2] and lane 0 runs first. After one intake cycle with `op_valid` low, the cell gives one cycle per opcode, with `op_valid` high and `op_code`/`op_slot` set to that lane.
- R3: Opcode 0 is never executed; it ends the cell early. In the last executed cycle (or in the intake cycle, when lane 0 is 0), `mem_addr` shows the current address plus one, and the following cycle takes in that cell.
- R4: A cell with bits [1:0] = 00 is a call. In its intake cycle, `rs_push` is high with `rs_push_data` = current address + 1, and `mem_addr` = bits [ADDR_W+1:2]. No opcode is executed, and the next cycle takes in the target cell.
- R5: The return opcode (code 1), in any lane, asserts `rs_pop` and drives `mem_addr` from `rs_top` in that cycle. It ends the cell.
- R6: The repeat opcode (code 2) is followed directly by lane 0 of the same cell. No intake cycle is spent and `mem_addr` keeps the current address.
- R7: While `exec_advance` is low during execution, the opcode, the lane and `mem_addr` hold. No push, no pop and no interrupt acknowledge occur.
- R8: An interrupt pending at a repeat opcode is taken instead of the wrap. In that cycle, `irq_ack` and `rs_push` are high, `rs_push_data` is the current cell address, and `mem_addr` is the vector (default 0x3F0).
- R9: An interrupt pending at the end of an ordinary cell is taken with `rs_push_data` = current address + 1. It is never taken in an intake cycle, and at a return it waits until the next cell end.
- R10: `rs_push` and `rs_pop` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | ADDR_W | Read address for the coming cycle |
| mem_rdata | input | 32 | Registered read data from program memory |
| exec_advance | input | 1 | Execute unit lets the current opcode retire |
| op_valid | output | 1 | An opcode is being executed this cycle |
| op_code | output | 6 | Opcode of the current lane |
| op_slot | output | 3 | Index of the current lane |
| rs_push | output | 1 | Push request to the return stack |
| rs_push_data | output | ADDR_W | Address to push |
| rs_pop | output | 1 | Pop request to the return stack |
| rs_top | input | ADDR_W | Current top of the return stack |
| irq_req | input | 1 | Level interrupt request |
| irq_ack | output | 1 | Interrupt taken this cycle |

## Verification
The hardest case to reach is an interrupt that arrives inside a repeat loop. It must be taken exactly at the wrap and must push the looping cell's own address. The bench first runs several wraps with no request, so that it can confirm no memory intake takes place. It then raises the request at lane 0 and holds it across the loop body. The bench checks that nothing is acknowledged before the repeat lane, and that the return from the vector resumes the same cell. Interrupts that are deferred at a return are reached through a call, so that the bench's stack model holds a real return address.

// File: rtl/cellseq_pkg.sv
package cellseq_pkg;

    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_FETCH = 2'd1,
        ST_EXEC  = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        OPK_NONE  = 2'd0,
        OPK_PLAIN = 2'd1,
        OPK_RET   = 2'd2,
        OPK_REP   = 2'd3
    } op_kind_e;

endpackage

// File: rtl/cellseq_slot_pick.sv
module cellseq_slot_pick #(
    parameter int OPC_W  = 6,
    parameter int SLOTS  = 5,
    parameter int SLOT_W = 3
) (
    input  logic [SLOTS*OPC_W-1:0] ops_i,
    input  logic [SLOT_W-1:0]      sel_i,
    output logic [OPC_W-1:0]       opc_o
);

    logic [OPC_W-1:0] lane [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_lane
        assign lane[g] = ops_i[g*OPC_W +: OPC_W];
    end

    // An index past the last lane reads as opcode 0, which ends the cell.
    always_comb begin
        opc_o = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (sel_i == SLOT_W'(i)) opc_o = lane[i];
        end
    end

endmodule

// File: rtl/cellseq_op_class.sv
module cellseq_op_class
    import cellseq_pkg::*;
#(
    parameter int OPC_W    = 6,
    parameter int RET_CODE = 1,
    parameter int REP_CODE = 2
) (
    input  logic [OPC_W-1:0] opc_i,
    output op_kind_e         kind_o
);

    always_comb begin
        if (opc_i == '0)                       kind_o = OPK_NONE;
        else if (opc_i == OPC_W'(RET_CODE))    kind_o = OPK_RET;
        else if (opc_i == OPC_W'(REP_CODE))    kind_o = OPK_REP;
        else                                   kind_o = OPK_PLAIN;
    end

endmodule

// File: rtl/cell_sequencer.sv
module cell_sequencer
    import cellseq_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int OPC_W    = 6,
    parameter int SLOTS    = 5,
    parameter int RET_CODE = 1,
    parameter int REP_CODE = 2,
    parameter int IRQ_VEC  = 'h3F0
) (
    input  logic                              clk,
    input  logic                              rst_n,
    output logic [ADDR_W-1:0]                 mem_addr,
    input  logic [SLOTS*OPC_W+1:0]            mem_rdata,
    input  logic                              exec_advance,
    output logic                              op_valid,
    output logic [OPC_W-1:0]                  op_code,
    output logic [$clog2(SLOTS+1)-1:0]        op_slot,
    output logic                              rs_push,
    output logic [ADDR_W-1:0]                 rs_push_data,
    output logic                              rs_pop,
    input  logic [ADDR_W-1:0]                 rs_top,
    input  logic                              irq_req,
    output logic                              irq_ack
);

    localparam int TAG_W  = 2;
    localparam int OPS_W  = SLOTS * OPC_W;
    localparam int CELL_W = OPS_W + TAG_W;
    localparam int SLOT_W = $clog2(SLOTS + 1);
    localparam logic [ADDR_W-1:0] VEC = ADDR_W'(IRQ_VEC);

    typedef struct packed {
        seq_state_e          st;
        logic [ADDR_W-1:0]   ip;
        logic [OPS_W-1:0]    ops;
        logic [SLOT_W-1:0]   slot;
    } seq_t;

    seq_t q, d;

    logic [TAG_W-1:0]  rd_tag;
    logic [OPS_W-1:0]  rd_ops;
    logic [ADDR_W-1:0] call_tgt;
    logic [ADDR_W-1:0] ip_inc;
    logic [SLOT_W-1:0] slot_inc;

    logic [OPC_W-1:0]  cur_opc, nxt_opc, first_opc;
    op_kind_e          cur_kind, nxt_kind, first_kind;

    assign rd_tag   = mem_rdata[TAG_W-1:0];
    assign rd_ops   = mem_rdata[CELL_W-1:TAG_W];
    assign call_tgt = mem_rdata[ADDR_W+TAG_W-1:TAG_W];
    assign ip_inc   = q.ip + 1'b1;
    assign slot_inc = q.slot + 1'b1;

    // Current lane, the lane after it, and lane 0 of the incoming cell
    cellseq_slot_pick #(.OPC_W(OPC_W), .SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_pick_cur (
        .ops_i(q.ops), .sel_i(q.slot), .opc_o(cur_opc)
    );
    cellseq_slot_pick #(.OPC_W(OPC_W), .SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_pick_nxt (
        .ops_i(q.ops), .sel_i(slot_inc), .opc_o(nxt_opc)
    );
    cellseq_slot_pick #(.OPC_W(OPC_W), .SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_pick_first (
        .ops_i(rd_ops), .sel_i('0), .opc_o(first_opc)
    );

    cellseq_op_class #(.OPC_W(OPC_W), .RET_CODE(RET_CODE), .REP_CODE(REP_CODE)) u_cls_cur (
        .opc_i(cur_opc), .kind_o(cur_kind)
    );
    cellseq_op_class #(.OPC_W(OPC_W), .RET_CODE(RET_CODE), .REP_CODE(REP_CODE)) u_cls_nxt (
        .opc_i(nxt_opc), .kind_o(nxt_kind)
    );
    cellseq_op_class #(.OPC_W(OPC_W), .RET_CODE(RET_CODE), .REP_CODE(REP_CODE)) u_cls_first (
        .opc_i(first_opc), .kind_o(first_kind)
    );

    always_comb begin
        d            = q;
        op_valid     = 1'b0;
        rs_push      = 1'b0;
        rs_push_data = ip_inc;
        rs_pop       = 1'b0;
        irq_ack      = 1'b0;

        unique case (q.st)
            ST_BOOT: begin
                // Address 0 is already on the RAM input; data arrives next cycle.
                d.st = ST_FETCH;
            end
            ST_FETCH: begin
                if (rd_tag == '0) begin
                    rs_push = 1'b1;
                    d.ip    = call_tgt;
                end else if (first_kind == OPK_NONE) begin
                    d.ip = ip_inc;
                end else begin
                    d.st   = ST_EXEC;
                    d.ops  = rd_ops;
                    d.slot = '0;
                end
            end
            ST_EXEC: begin
                op_valid = 1'b1;
                if (exec_advance) begin
                    unique case (cur_kind)
                        OPK_RET: begin
                            rs_pop = 1'b1;
                            d.ip   = rs_top;
                            d.st   = ST_FETCH;
                        end
                        OPK_REP: begin
                            if (irq_req) begin
                                irq_ack      = 1'b1;
                                rs_push      = 1'b1;
                                rs_push_data = q.ip;
                                d.ip         = VEC;
                                d.st         = ST_FETCH;
                            end else begin
                                d.slot = '0;
                            end
                        end
                        default: begin
                            if (nxt_kind == OPK_NONE) begin
                                d.st = ST_FETCH;
                                if (irq_req) begin
                                    irq_ack = 1'b1;
                                    rs_push = 1'b1;
                                    d.ip    = VEC;
                                end else begin
                                    d.ip = ip_inc;
                                end
                            end else begin
                                d.slot = slot_inc;
                            end
                        end
                    endcase
                end
            end
            default: d.st = ST_FETCH;
        endcase
    end

    assign mem_addr = d.ip;
    assign op_code  = cur_opc;
    assign op_slot  = q.slot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_BOOT;
            q.ip   <= '0;
            q.ops  <= '0;
            q.slot <= '0;
        end else begin
            q <= d;
        end
    end

    // ---------------- assertions ----------------
    p_call_no_exec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FETCH && rd_tag == '0) |=> !op_valid);

    p_ret_ends_cell_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rs_pop |=> !op_valid);

    p_rep_wraps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && exec_advance && op_code == OPC_W'(REP_CODE) && !irq_ack)
        |=> (op_valid && op_slot == '0));

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !exec_advance) |=> (op_valid && $stable(op_code) && $stable(op_slot)));

    p_stall_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !exec_advance) |-> (!rs_push && !rs_pop && !irq_ack));

    p_ack_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (rs_push && mem_addr == VEC));

    p_ack_refetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !op_valid);

    p_push_pop_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rs_push && rs_pop));

endmodule

// File: tb/cell_sequencer_test.sv
`timescale 1ns/100ps
module cell_sequencer_test;

    localparam int AW  = 10;
    localparam int VEC = 'h3F0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_rdata;
    logic          exec_advance = 1'b1;
    logic          op_valid;
    logic [5:0]    op_code;
    logic [2:0]    op_slot;
    logic          rs_push;
    logic [AW-1:0] rs_push_data;
    logic          rs_pop;
    logic [AW-1:0] rs_top;
    logic          irq_req = 1'b0;
    logic          irq_ack;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    cell_sequencer uut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .exec_advance(exec_advance), .op_valid(op_valid), .op_code(op_code),
        .op_slot(op_slot), .rs_push(rs_push), .rs_push_data(rs_push_data),
        .rs_pop(rs_pop), .rs_top(rs_top), .irq_req(irq_req), .irq_ack(irq_ack)
    );

    // Program memory with registered read
    logic [31:0] mem [0:1023];
    always_ff @(posedge clk) mem_rdata <= mem[mem_addr];

    // Return stack model
    logic [AW-1:0] stk [0:15];
    int sp;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sp <= 0;
        else if (rs_push) begin
            stk[sp[3:0]] <= rs_push_data;
            sp <= sp + 1;
        end else if (rs_pop && sp > 0) sp <= sp - 1;
    end
    assign rs_top = (sp > 0) ? stk[4'(sp - 1)] : '0;

    function automatic logic [31:0] mk5(input logic [5:0] o0, o1, o2, o3, o4,
                                        input logic [1:0] tag);
        return {o4, o3, o2, o1, o0, tag};
    endfunction

    function automatic logic [31:0] mk_run(input int k, input int base, input logic [1:0] tag);
        logic [31:0] c = {30'd0, tag};
        for (int i = 0; i < k; i++) c[6*i+2 +: 6] = 6'(base + i);
        return c;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 1024; i++) mem[i] = 32'h1;
    endtask

    // Reset, then sample the first cycle after release (R1)
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; exec_advance = 1'b1; irq_req = 1'b0;
        #1;
        check("R1 addr in reset", 32'(mem_addr), 0);
        check("R1 valid in reset", 32'(op_valid), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 valid after release", 32'(op_valid), 0);
        check("R1 addr after release", 32'(mem_addr), 0);
    endtask

    task automatic step(input logic adv, input logic irq);
        @(negedge clk);
        exec_advance = adv;
        irq_req = irq;
        #1;
    endtask

    initial begin
        // ---- R2/R3: cell length and tag sweep ----
        for (int tag = 1; tag < 4; tag++) begin
            for (int k = 0; k < 6; k++) begin
                clear_mem();
                mem[0] = mk_run(k, 'h10, 2'(tag));
                mem[1] = mk_run(1, 'h20, 2'd1);
                do_reset();
                step(1, 0);
                check("R2 intake valid", 32'(op_valid), 0);
                check("R3 intake addr", 32'(mem_addr), (k == 0) ? 1 : 0);
                for (int i = 0; i < k; i++) begin
                    step(1, 0);
                    check("R2 valid", 32'(op_valid), 1);
                    check("R2 code", 32'(op_code), 32'('h10 + i));
                    check("R2 slot", 32'(op_slot), 32'(i));
                    check("R3 addr", 32'(mem_addr), (i == k - 1) ? 1 : 0);
                end
                step(1, 0);
                check("R3 next intake", 32'(op_valid), 0);
                step(1, 0);
                check("R3 next cell code", 32'(op_code), 'h20);
            end
        end

        // ---- R4/R5: call targets and return lane sweep ----
        for (int tgt = 2; tgt < 10; tgt++) begin
            for (int j = 0; j < 5; j++) begin
                clear_mem();
                mem[0] = 32'(tgt) << 2;
                mem[tgt] = mk_run(j, 'h30, 2'd2);
                mem[tgt][6*j+2 +: 6] = 6'd1;
                mem[1] = mk_run(1, 'h21, 2'd3);
                do_reset();
                step(1, 0);
                check("R4 push", 32'(rs_push), 1);
                check("R4 push data", 32'(rs_push_data), 1);
                check("R4 target addr", 32'(mem_addr), 32'(tgt));
                check("R4 no exec", 32'(op_valid), 0);
                step(1, 0);
                check("R4 target intake", 32'(op_valid), 0);
                check("R10 quiet", 32'(rs_push), 0);
                for (int i = 0; i < j; i++) begin
                    step(1, 0);
                    check("R5 pre-ret code", 32'(op_code), 32'('h30 + i));
                end
                step(1, 0);
                check("R5 ret code", 32'(op_code), 1);
                check("R5 pop", 32'(rs_pop), 1);
                check("R10 no push at pop", 32'(rs_push), 0);
                check("R5 return addr", 32'(mem_addr), 1);
                step(1, 0);
                check("R5 intake", 32'(op_valid), 0);
                step(1, 0);
                check("R5 resumed", 32'(op_code), 'h21);
            end
        end

        // ---- R7: stall at each lane, with interrupt pending ----
        clear_mem();
        mem[0] = mk5(6'h11, 6'h12, 6'h13, 0, 0, 2'd1);
        do_reset();
        step(1, 0);
        for (int s = 0; s < 3; s++) begin
            for (int n = 0; n <= s; n++) begin
                step(0, 1);
                check("R7 held valid", 32'(op_valid), 1);
                check("R7 held code", 32'(op_code), 32'('h11 + s));
                check("R7 held slot", 32'(op_slot), 32'(s));
                check("R7 held addr", 32'(mem_addr), 0);
                check("R7 no push", 32'(rs_push), 0);
                check("R7 no ack", 32'(irq_ack), 0);
            end
            step(1, 0);
            check("R7 released code", 32'(op_code), 32'('h11 + s));
            check("R7 released addr", 32'(mem_addr), (s == 2) ? 1 : 0);
        end

        // ---- R6/R8: repeat loop, then interrupt at the wrap ----
        clear_mem();
        mem[0]   = mk5(6'h11, 6'h12, 6'd2, 0, 0, 2'd1);
        mem[VEC] = mk5(6'd1, 0, 0, 0, 0, 2'd1);
        do_reset();
        step(1, 0);
        for (int it = 0; it < 3; it++) begin
            step(1, 0);
            check("R6 lane0 code", 32'(op_code), 'h11);
            check("R6 lane0 slot", 32'(op_slot), 0);
            check("R6 no intake", 32'(op_valid), 1);
            step(1, 0);
            check("R6 lane1 code", 32'(op_code), 'h12);
            step(1, 0);
            check("R6 rep code", 32'(op_code), 2);
            check("R6 rep addr", 32'(mem_addr), 0);
            check("R6 rep no push", 32'(rs_push), 0);
        end
        step(1, 1);
        check("R8 wait lane0", 32'(irq_ack), 0);
        step(1, 1);
        check("R8 wait lane1", 32'(irq_ack), 0);
        step(1, 1);
        check("R8 ack", 32'(irq_ack), 1);
        check("R8 push", 32'(rs_push), 1);
        check("R8 push current", 32'(rs_push_data), 0);
        check("R8 vector", 32'(mem_addr), VEC);
        step(1, 0);
        check("R8 vector intake", 32'(op_valid), 0);
        step(1, 0);
        check("R8 handler ret", 32'(rs_pop), 1);
        check("R8 back to cell", 32'(mem_addr), 0);
        step(1, 0);
        step(1, 0);
        check("R8 loop resumes", 32'(op_code), 'h11);

        // ---- R9: interrupt at ordinary cell end, length sweep ----
        for (int n = 1; n < 6; n++) begin
            clear_mem();
            mem[0]   = mk_run(n, 'h11, 2'd1);
            mem[1]   = mk_run(1, 'h25, 2'd1);
            mem[VEC] = mk5(6'd1, 0, 0, 0, 0, 2'd1);
            do_reset();
            step(1, 1);
            check("R9 no ack at intake", 32'(irq_ack), 0);
            for (int i = 0; i < n; i++) begin
                step(1, 1);
                check("R9 ack timing", 32'(irq_ack), (i == n - 1) ? 1 : 0);
                if (i == n - 1) begin
                    check("R9 push next", 32'(rs_push_data), 1);
                    check("R9 vector", 32'(mem_addr), VEC);
                end
            end
            step(1, 0);
            step(1, 0);
            check("R9 handler return", 32'(mem_addr), 1);
            step(1, 0);
            step(1, 0);
            check("R9 resumed", 32'(op_code), 'h25);
        end

        // ---- R9: interrupt waits past a return ----
        clear_mem();
        mem[0] = 32'd4 << 2;
        mem[4] = mk5(6'd1, 0, 0, 0, 0, 2'd1);
        mem[1] = mk5(6'h26, 0, 0, 0, 0, 2'd1);
        do_reset();
        step(1, 1);
        check("R9 no ack at call", 32'(irq_ack), 0);
        step(1, 1);
        step(1, 1);
        check("R9 ret no ack", 32'(irq_ack), 0);
        check("R9 ret pops", 32'(rs_pop), 1);
        check("R9 ret addr", 32'(mem_addr), 1);
        step(1, 1);
        check("R9 no ack intake", 32'(irq_ack), 0);
        step(1, 1);
        check("R9 deferred ack", 32'(irq_ack), 1);
        check("R9 deferred push", 32'(rs_push_data), 2);
        check("R9 deferred vector", 32'(mem_addr), VEC);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule